// File: doc/BRIEF.md
# Packed Colour Palette RAM

This block holds a 256-entry colour palette for a display pipeline. Entries are 16 bits wide and stored two to a 32-bit word, so the array has 128 words. Software fills and inspects the palette through a word-addressed bus window. The display datapath uses a separate lookup port that turns an 8-bit pixel index into a 24-bit RGB value.

Each entry packs three 5-bit colour components and one intensity bit. The lookup path widens every component to 8 bits by appending three zero bits and discards the intensity bit. A bus read returns the stored word unchanged, so the intensity bits read back exactly as they were written.

The bus side uses plain strobes. A read returns data one cycle later with a valid pulse. The lookup side is a valid/ready stream. An index is accepted when `idx_valid` and `idx_ready` are both high at a clock edge. The colour appears on `rgb_data` with `rgb_valid` after that edge. While `rgb_valid` is high and `rgb_ready` is low, the output holds its value and `idx_ready` stays low, so no new index is taken. An output slot that is free, or that is being drained in the same cycle, accepts a new index.

Top module: `palette_ram`

## Requirements
- R1: After reset every palette word is zero, so any lookup returns 24'h000000 and any bus read returns 32'h0. `rgb_valid` and `bus_rd_valid` are low.
- R2: A bus write at byte offset 0x200 + 4n (n = 0..127) stores the full 32-bit word n. A bus read at that offset drives `bus_rdata` with all 32 bits last written, including bits 15 and 31, on the cycle after `bus_rd_en`, with `bus_rd_valid` high in that cycle. Address bits [1:0] are ignored.
- R3: A lookup of index i selects word i[7:1]. Index bit 0 picks the half: 0 selects bits [15:0] (entry 2n), and 1 selects bits [31:16] (entry 2n+1).
- R4: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. `rgb_data` carries red in [7:0], green in [15:8] and blue in [23:16], and each component equals its 5-bit value shifted left by 3, so the low 3 bits are zero.
- R5: The intensity bit (bit 15 of each entry) has no effect on `rgb_data`.
- R6: An index accepted at clock edge k gives `rgb_valid` high with its colour on `rgb_data` right after edge k, one cycle of latency.
- R7: While `rgb_valid` is high and `rgb_ready` is low, `rgb_data` and `rgb_valid` hold and `idx_ready` is low.
- R8: When a bus write and an accepted lookup address the same word in the same cycle, the lookup returns the colour from the word as it was before the write.
- R9: A bus write outside byte offsets 0x200..0x3FF changes no palette word. A bus read outside that range returns 32'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, one cycle after the strobe |
| bus_rd_valid | output | 1 | High in the cycle `bus_rdata` is valid |
| idx_valid | input | 1 | Pixel index is offered |
| idx_ready | output | 1 | Lookup stage can take an index |
| idx_data | input | 8 | Pixel index |
| rgb_valid | output | 1 | Colour output is valid |
| rgb_ready | input | 1 | Consumer takes the colour |
| rgb_data | output | 24 | Colour: blue [23:16], green [15:8], red [7:0] |

## Verification
A word stored at the wrong index, or a half-select that is inverted, shows up as a wrong colour on the first lookup of either entry of the affected word. It also shows up as wrong data on the next bus read of that word, one cycle after the read strobe. A stuck or leaking intensity bit changes `rgb_data` on the very next lookup of an entry whose bit 15 is set. A decode that lets writes through outside the window corrupts a word, and a full read-back sweep exposes that within 128 reads. A stall-register fault shows within one cycle as a changed `rgb_data` while `rgb_ready` is low, or as an index taken while the output is blocked.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int COMP_IN_W  = 5;
  localparam int COMP_OUT_W = 8;
  localparam int NUM_COMP   = 3;
  localparam int ENTRY_W    = 16;
  localparam int WORD_W     = 2 * ENTRY_W;
  localparam int RGB_W      = NUM_COMP * COMP_OUT_W;
  localparam int PAD_W      = COMP_OUT_W - COMP_IN_W;

  typedef logic [WORD_W-1:0]  pal_word_t;
  typedef logic [ENTRY_W-1:0] pal_entry_t;
  typedef logic [RGB_W-1:0]   rgb_t;

  // Widen one component by appending zero bits below it.
  function automatic logic [COMP_OUT_W-1:0] widen_comp(input logic [COMP_IN_W-1:0] c);
    return {c, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int WORDS   = 128,
  localparam int WORD_AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [WORD_AW-1:0] waddr,
  input  pal_word_t          wdata,
  input  logic [WORD_AW-1:0] raddr_bus,
  output pal_word_t          rdata_bus,
  input  logic [WORD_AW-1:0] raddr_pix,
  output pal_word_t          rdata_pix
);
  pal_word_t mem [WORDS];

  // Reads see the array before this edge's write lands.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_bus = mem[raddr_bus];
  assign rdata_pix = mem[raddr_pix];
endmodule

// File: rtl/palette_expand.sv
module palette_expand
  import palette_pkg::*;
(
  input  pal_word_t word_in,
  input  logic      half_sel,
  output rgb_t      rgb_out
);
  pal_entry_t entry;
  logic       unused_intensity;

  assign entry = half_sel ? word_in[WORD_W-1:ENTRY_W] : word_in[ENTRY_W-1:0];
  assign unused_intensity = entry[ENTRY_W-1];

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    assign rgb_out[c*COMP_OUT_W +: COMP_OUT_W] = widen_comp(entry[c*COMP_IN_W +: COMP_IN_W]);
  end
endmodule

// File: rtl/palette_bus_port.sv
module palette_bus_port
  import palette_pkg::*;
#(
  parameter int               ADDR_W      = 12,
  parameter int               WORDS       = 128,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 12'h200,
  localparam int              WORD_AW     = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               store_we,
  output logic [WORD_AW-1:0] word_idx,
  input  pal_word_t          store_rdata,
  output pal_word_t          bus_rdata,
  output logic               bus_rd_valid
);
  localparam logic [ADDR_W:0] LIMIT = {1'b0, WINDOW_BASE} + (ADDR_W+1)'(WORDS * 4);

  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic              unused_offset_bits;

  assign offset   = bus_addr - WINDOW_BASE;
  assign hit      = (bus_addr >= WINDOW_BASE) && ({1'b0, bus_addr} < LIMIT);
  assign word_idx = offset[WORD_AW+1:2];
  assign unused_offset_bits = ^{offset[1:0], offset[ADDR_W-1:WORD_AW+2]};
  assign store_we = bus_wr_en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      bus_rd_valid <= 1'b0;
    end else begin
      bus_rd_valid <= bus_rd_en;
      bus_rdata    <= (bus_rd_en && hit) ? store_rdata : '0;
    end
  end

  // R9: a read that misses the window returns zero next cycle
  assert_outside_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !hit) |=> (bus_rdata == '0));

  // R2: read data is flagged valid exactly one cycle after the strobe
  assert_read_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rd_valid);
endmodule

// File: rtl/palette_lookup_stage.sv
module palette_lookup_stage
  import palette_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic idx_valid,
  output logic idx_ready,
  input  rgb_t rgb_in,
  output logic rgb_valid,
  input  logic rgb_ready,
  output rgb_t rgb_data
);
  logic take;

  assign idx_ready = !rgb_valid || rgb_ready;
  assign take      = idx_valid && idx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb_data  <= '0;
    end else if (take) begin
      rgb_valid <= 1'b1;
      rgb_data  <= rgb_in;
    end else if (rgb_ready) begin
      rgb_valid <= 1'b0;
    end
  end

  // R6: an accepted index is on the output after one edge
  assert_valid_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && idx_ready) |=> rgb_valid);

  // R7: a stalled output keeps its value
  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && !rgb_ready) |=> (rgb_valid && $stable(rgb_data)));

  // R4: every widened component has zero low bits
  assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid |-> (rgb_data[2:0] == 3'b000 && rgb_data[10:8] == 3'b000 &&
                   rgb_data[18:16] == 3'b000));
endmodule

// File: rtl/palette_ram.sv
module palette_ram
  import palette_pkg::*;
#(
  parameter int               ENTRY_COUNT = 256,
  parameter int               ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] WINDOW_BASE = 12'h200,
  localparam int              WORDS       = ENTRY_COUNT / 2,
  localparam int              WORD_AW     = $clog2(WORDS),
  localparam int              IDX_W       = $clog2(ENTRY_COUNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                bus_rd_valid,
  input  logic                idx_valid,
  output logic                idx_ready,
  input  logic [IDX_W-1:0]    idx_data,
  output logic                rgb_valid,
  input  logic                rgb_ready,
  output logic [RGB_W-1:0]    rgb_data
);
  logic               store_we;
  logic [WORD_AW-1:0] bus_word;
  pal_word_t          bus_word_data;
  pal_word_t          pix_word_data;
  rgb_t               pix_rgb;

  palette_bus_port #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .WINDOW_BASE(WINDOW_BASE)
  ) bus_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .store_we(store_we), .word_idx(bus_word), .store_rdata(bus_word_data),
    .bus_rdata(bus_rdata), .bus_rd_valid(bus_rd_valid)
  );

  palette_store #(.WORDS(WORDS)) store_i (
    .clk(clk), .rst_n(rst_n),
    .we(store_we), .waddr(bus_word), .wdata(bus_wdata),
    .raddr_bus(bus_word), .rdata_bus(bus_word_data),
    .raddr_pix(idx_data[IDX_W-1:1]), .rdata_pix(pix_word_data)
  );

  palette_expand expand_i (
    .word_in(pix_word_data), .half_sel(idx_data[0]), .rgb_out(pix_rgb)
  );

  palette_lookup_stage stage_i (
    .clk(clk), .rst_n(rst_n),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .rgb_in(pix_rgb),
    .rgb_valid(rgb_valid), .rgb_ready(rgb_ready), .rgb_data(rgb_data)
  );
endmodule

// File: tb/palette_ram_tb.sv
module palette_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rd_valid;
  logic        idx_valid, idx_ready, rgb_valid, rgb_ready;
  logic [7:0]  idx_data;
  logic [23:0] rgb_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [31:0] shadow [128];

  always #5 clk = ~clk;

  palette_ram dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_valid(bus_rd_valid),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
    .rgb_valid(rgb_valid), .rgb_ready(rgb_ready), .rgb_data(rgb_data)
  );

  function automatic logic [23:0] model_rgb(input logic [31:0] w, input logic half);
    logic [15:0] e;
    e = half ? w[31:16] : w[15:0];
    return {e[14:10], 3'b000, e[9:5], 3'b000, e[4:0], 3'b000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
    if (a >= 12'h200 && a < 12'h400) shadow[(a - 12'h200) >> 2] = d;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata; v = bus_rd_valid;
  endtask

  task automatic lookup(input logic [7:0] i, output logic [23:0] c, output logic v);
    @(negedge clk);
    rgb_ready = 1'b1; idx_valid = 1'b1; idx_data = i;
    @(negedge clk);
    idx_valid = 1'b0;
    c = rgb_data; v = rgb_valid;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [23:0] c; logic v;
    chk("R1 rgb_valid after reset", {31'b0, rgb_valid}, 32'h0);
    chk("R1 rd_valid after reset", {31'b0, bus_rd_valid}, 32'h0);
    bus_read(12'h200, d, v); chk("R1 word0 zero", d, 32'h0);
    bus_read(12'h3FC, d, v); chk("R1 word127 zero", d, 32'h0);
    lookup(8'd255, c, v);    chk("R1 lookup 255 zero", {8'h0, c}, 32'h0);
  endtask

  task automatic t_readback;
    logic [31:0] d; logic v;
    bus_write(12'h200, 32'h8000_FFFF);
    bus_write(12'h3FC, 32'hDEAD_BEEF);
    bus_write(12'h2A4, 32'h1234_5678);
    bus_read(12'h200, d, v); chk("R2 word0 readback", d, 32'h8000_FFFF);
    chk("R2 rd_valid one cycle later", {31'b0, v}, 32'h1);
    bus_read(12'h3FC, d, v); chk("R2 word127 readback", d, 32'hDEAD_BEEF);
    bus_read(12'h2A7, d, v); chk("R2 low address bits ignored", d, 32'h1234_5678);
  endtask

  task automatic t_halves;
    logic [23:0] c; logic v;
    bus_write(12'h240, 32'h7C1F_03E0);  // word 16: low=green max, high=red+blue max
    lookup(8'd32, c, v); chk("R3 low half entry 32", {8'h0, c}, {8'h0, model_rgb(shadow[16], 1'b0)});
    chk("R4 green field to [15:8]", {8'h0, c}, 32'h0000_F800);
    lookup(8'd33, c, v); chk("R3 high half entry 33", {8'h0, c}, 32'h00F8_00F8);
    bus_write(12'h3FC, 32'h0421_2D6B);
    lookup(8'd255, c, v); chk("R3 entry 255", {8'h0, c}, {8'h0, model_rgb(shadow[127], 1'b1)});
    lookup(8'd254, c, v); chk("R4 mixed components 254", {8'h0, c}, {8'h0, model_rgb(shadow[127], 1'b0)});
  endtask

  task automatic t_intensity;
    logic [23:0] c0, c1; logic v;
    bus_write(12'h260, 32'h1234_1234);
    lookup(8'd48, c0, v);
    bus_write(12'h260, 32'h9234_9234);
    lookup(8'd48, c1, v); chk("R5 intensity low half", {8'h0, c1}, {8'h0, c0});
    lookup(8'd49, c1, v); chk("R5 intensity high half", {8'h0, c1}, {8'h0, c0});
  endtask

  task automatic t_latency;
    bus_write(12'h280, 32'h0000_7FFF);
    @(negedge clk);
    rgb_ready = 1'b1; idx_valid = 1'b1; idx_data = 8'd64;
    chk("R6 not valid before edge", {31'b0, rgb_valid}, 32'h0);
    @(negedge clk);
    idx_valid = 1'b0;
    chk("R6 valid after one edge", {31'b0, rgb_valid}, 32'h1);
    chk("R6 colour after one edge", {8'h0, rgb_data}, 32'h00F8_F8F8);
    @(negedge clk);
    chk("R6 drained", {31'b0, rgb_valid}, 32'h0);
  endtask

  task automatic t_backpressure;
    bus_write(12'h300, 32'h0000_001F);  // word 64 -> index 128
    bus_write(12'h304, 32'h0000_7C00);  // word 65 -> index 130
    @(negedge clk);
    rgb_ready = 1'b0; idx_valid = 1'b1; idx_data = 8'd128;
    chk("R7 ready when empty", {31'b0, idx_ready}, 32'h1);
    @(negedge clk);
    idx_data = 8'd130;
    chk("R7 first colour", {8'h0, rgb_data}, 32'h0000_00F8);
    chk("R7 not ready when blocked", {31'b0, idx_ready}, 32'h0);
    @(negedge clk);
    chk("R7 colour held", {8'h0, rgb_data}, 32'h0000_00F8);
    chk("R7 valid held", {31'b0, rgb_valid}, 32'h1);
    rgb_ready = 1'b1;
    @(negedge clk);
    idx_valid = 1'b0;
    chk("R7 second colour after release", {8'h0, rgb_data}, 32'h00F8_0000);
    @(negedge clk);
    chk("R7 drained", {31'b0, rgb_valid}, 32'h0);
  endtask

  task automatic t_collision;
    logic [23:0] c; logic v; logic [31:0] old_w;
    bus_write(12'h214, 32'h0000_001F);  // word 5
    old_w = shadow[5];
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 12'h214; bus_wdata = 32'h0000_03E0;
    rgb_ready = 1'b1; idx_valid = 1'b1; idx_data = 8'd10;
    @(negedge clk);
    bus_wr_en = 1'b0; idx_valid = 1'b0;
    shadow[5] = 32'h0000_03E0;
    chk("R8 same-cycle lookup sees old word", {8'h0, rgb_data}, {8'h0, model_rgb(old_w, 1'b0)});
    lookup(8'd10, c, v); chk("R8 later lookup sees new word", {8'h0, c}, 32'h0000_F800);
  endtask

  task automatic t_outside;
    logic [31:0] d; logic v; int bad;
    bus_write(12'h1FC, 32'hAAAA_AAAA);
    bus_write(12'h400, 32'h5555_5555);
    bus_write(12'h000, 32'hFFFF_FFFF);
    bus_write(12'hFFC, 32'h0F0F_0F0F);
    bus_read(12'h1FC, d, v); chk("R9 read below window", d, 32'h0);
    bus_read(12'h400, d, v); chk("R9 read above window", d, 32'h0);
    bad = 0;
    for (int w = 0; w < 128; w++) begin
      bus_read(12'h200 + 12'(w * 4), d, v);
      if (d !== shadow[w]) begin
        bad++;
        $display("FAIL R9 word %0d actual=%h expected=%h", w, d, shadow[w]);
      end
    end
    chk("R9 no word changed by outside writes", bad, 32'h0);
  endtask

  initial begin
    for (int w = 0; w < 128; w++) shadow[w] = 32'h0;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    idx_valid = 1'b0; idx_data = '0; rgb_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_halves();
    t_intensity();
    t_latency();
    t_backpressure();
    t_collision();
    t_outside();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule